// File: doc/BRIEF.md
# S/PDIF Channel-Status Capture

This block gathers the channel-status bits carried by the C bit of incoming S/PDIF subframes. A decoder ahead of it supplies one strobe per decoded subframe, together with the C bit, a flag telling whether the subframe belongs to channel A or channel B, and a flag that marks the first frame of a 192-frame block. A configuration bit selects which of the two channels is captured.

The 192 collected bits are written into a shadow buffer. That buffer is copied into a readable copy only when a complete block has arrived. A reader therefore always sees one whole block and never a mix of two. The readable copy is exposed as six 32-bit words through a 3-bit word index. A valid flag reports that at least one complete block has been captured since reset.

Top module: `cstat_capture`

## Requirements
- R1: A subframe is accepted only when `sub_b_i` equals `chan_sel_i` (0 selects channel A, 1 selects channel B). C bits of subframes from the other channel never reach the captured block.
- R2: A strobe with `blk_start_i` set marks a new block. If that strobe is from the selected channel, its own C bit becomes bit 0. Otherwise the next accepted subframe carries bit 0.
- R3: Bit n of a block is stored in status byte n/8 at bit position n mod 8, LSB first. Word index i returns status byte 4*i+j in bits 8*j+7 down to 8*j. So block bit n appears in word n/32 at bit n mod 32.
- R4: The readable words change only on the clock edge that accepts bit 191 of a block. Until then, the previous complete block stays readable.
- R5: A block start that arrives before bit 191 restarts the count at 0 and discards the partial block. That block is then committed only 192 accepted bits after the new start.
- R6: Accepted subframes are ignored while no block is open. This covers the time after reset before the first start, and the time after bit 191 until the next start.
- R7: Word indices 6 and 7 read as zero.
- R8: `valid_o` is low after reset. It goes high on the edge that commits the first complete block and stays high until the next reset.
- R9: Reset clears both the shadow and the readable copy, so every word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_vld_i | input | 1 | One-cycle strobe per decoded subframe |
| cbit_i | input | 1 | Channel-status bit of the strobed subframe |
| sub_b_i | input | 1 | Subframe is channel B (0 = channel A) |
| blk_start_i | input | 1 | Strobed subframe belongs to the first frame of a block |
| chan_sel_i | input | 1 | Channel to capture (0 = A, 1 = B) |
| word_idx_i | input | 3 | Index of the status word to read |
| word_o | output | 32 | Selected status word |
| valid_o | output | 1 | A complete block has been captured |

## Verification
The hardest case to bring about is a block start that is repeated part-way through a block. After the restart, exactly 192 bits have gone by since the first start, yet the design must not commit. Only a block of 192 bits counted from the restart may commit. The bench sends 100 bits of one pattern, restarts with a second pattern, and stops after 92 bits to confirm that the old words are still readable. It then completes the second block and checks that it is the one that appears. The commit boundary is also probed: the words are read one frame before bit 191 and again right after it.

// File: rtl/cstat_pkg.sv
package cstat_pkg;
  localparam int unsigned BLK_BITS_DEF = 192;
  localparam int unsigned WORD_W_DEF   = 32;
  localparam int unsigned IDX_W_DEF    = 3;

  // block sequencer: hunting for a start, or filling a block
  typedef enum logic {
    SEQ_HUNT = 1'b0,
    SEQ_FILL = 1'b1
  } seq_state_e;
endpackage

// File: rtl/cstat_sel.sv
module cstat_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_vld_i,
  input  logic sub_b_i,
  input  logic blk_start_i,
  input  logic chan_sel_i,
  output logic acc_o,
  output logic start_o
);
  logic pend_q;
  logic acc;
  logic foreign_start;

  assign acc           = frame_vld_i && (sub_b_i == chan_sel_i);
  assign foreign_start = frame_vld_i && !acc && blk_start_i;

  // a start seen on the other channel opens the block at our next subframe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pend_q <= 1'b0;
    else if (acc)           pend_q <= 1'b0;
    else if (foreign_start) pend_q <= 1'b1;
  end

  assign acc_o   = acc;
  assign start_o = acc && (blk_start_i || pend_q);
endmodule

// File: rtl/cstat_seq.sv
module cstat_seq
  import cstat_pkg::*;
#(
  parameter int unsigned BLK_BITS = BLK_BITS_DEF,
  localparam int unsigned CNT_W   = $clog2(BLK_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             start_i,
  input  logic             cbit_i,
  output logic             wr_en_o,
  output logic [CNT_W-1:0] wr_idx_o,
  output logic             wr_bit_o,
  output logic             commit_o,
  output logic [CNT_W-1:0] cnt_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_en;
  logic [CNT_W-1:0] wr_idx;
  logic             last;

  assign wr_en  = acc_i && (start_i || (state_q == SEQ_FILL));
  assign wr_idx = start_i ? '0 : cnt_q;
  assign last   = wr_en && (wr_idx == CNT_W'(BLK_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_HUNT;
      cnt_q   <= '0;
    end else if (wr_en) begin
      if (last) begin
        state_q <= SEQ_HUNT;
        cnt_q   <= '0;
      end else begin
        state_q <= SEQ_FILL;
        cnt_q   <= wr_idx + CNT_W'(1);
      end
    end
  end

  assign wr_en_o  = wr_en;
  assign wr_idx_o = wr_idx;
  assign wr_bit_o = cbit_i;
  assign commit_o = last;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/cstat_store.sv
module cstat_store
  import cstat_pkg::*;
#(
  parameter int unsigned BLK_BITS = BLK_BITS_DEF,
  localparam int unsigned CNT_W   = $clog2(BLK_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [CNT_W-1:0]    wr_idx_i,
  input  logic                wr_bit_i,
  input  logic                commit_i,
  output logic [BLK_BITS-1:0] live_o,
  output logic                valid_o
);
  logic [BLK_BITS-1:0] shadow_q;
  logic [BLK_BITS-1:0] shadow_nxt;
  logic [BLK_BITS-1:0] live_q;
  logic                valid_q;

  // merged view lets the final bit land in the readable copy on its own edge
  for (genvar b = 0; b < BLK_BITS; b++) begin : g_bit
    assign shadow_nxt[b] = (wr_en_i && (wr_idx_i == CNT_W'(b))) ? wr_bit_i : shadow_q[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      shadow_q <= '0;
    else if (wr_en_i) shadow_q <= shadow_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q  <= '0;
      valid_q <= 1'b0;
    end else if (commit_i) begin
      live_q  <= shadow_nxt;
      valid_q <= 1'b1;
    end
  end

  assign live_o  = live_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/cstat_rdmux.sv
module cstat_rdmux
  import cstat_pkg::*;
#(
  parameter int unsigned BLK_BITS  = BLK_BITS_DEF,
  parameter int unsigned WORD_W    = WORD_W_DEF,
  parameter int unsigned IDX_W     = IDX_W_DEF,
  localparam int unsigned NUM_WORDS = BLK_BITS / WORD_W,
  localparam int unsigned WIN_N     = 1 << IDX_W
) (
  input  logic [BLK_BITS-1:0] live_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [WORD_W-1:0]   word_o
);
  logic [WORD_W-1:0] win [WIN_N];

  for (genvar w = 0; w < WIN_N; w++) begin : g_win
    if (w < NUM_WORDS) begin : g_used
      assign win[w] = live_i[w*WORD_W +: WORD_W];
    end else begin : g_pad
      assign win[w] = '0;
    end
  end

  assign word_o = win[idx_i];
endmodule

// File: rtl/cstat_capture.sv
module cstat_capture
  import cstat_pkg::*;
#(
  parameter int unsigned BLK_BITS = BLK_BITS_DEF,
  parameter int unsigned WORD_W   = WORD_W_DEF,
  parameter int unsigned IDX_W    = IDX_W_DEF,
  localparam int unsigned CNT_W   = $clog2(BLK_BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_vld_i,
  input  logic              cbit_i,
  input  logic              sub_b_i,
  input  logic              blk_start_i,
  input  logic              chan_sel_i,
  input  logic [IDX_W-1:0]  word_idx_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  logic                acc_w;
  logic                start_w;
  logic                wr_en_w;
  logic [CNT_W-1:0]    wr_idx_w;
  logic                wr_bit_w;
  logic                commit_w;
  logic [CNT_W-1:0]    bit_cnt_w;
  logic [BLK_BITS-1:0] live_w;

  cstat_sel u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_vld_i (frame_vld_i),
    .sub_b_i     (sub_b_i),
    .blk_start_i (blk_start_i),
    .chan_sel_i  (chan_sel_i),
    .acc_o       (acc_w),
    .start_o     (start_w)
  );

  cstat_seq #(.BLK_BITS(BLK_BITS)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_i    (acc_w),
    .start_i  (start_w),
    .cbit_i   (cbit_i),
    .wr_en_o  (wr_en_w),
    .wr_idx_o (wr_idx_w),
    .wr_bit_o (wr_bit_w),
    .commit_o (commit_w),
    .cnt_o    (bit_cnt_w)
  );

  cstat_store #(.BLK_BITS(BLK_BITS)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_w),
    .wr_idx_i (wr_idx_w),
    .wr_bit_i (wr_bit_w),
    .commit_i (commit_w),
    .live_o   (live_w),
    .valid_o  (valid_o)
  );

  cstat_rdmux #(.BLK_BITS(BLK_BITS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_rdmux (
    .live_i (live_w),
    .idx_i  (word_idx_i),
    .word_o (word_o)
  );
endmodule

// File: rtl/cstat_capture_chk.sv
module cstat_capture_chk
  import cstat_pkg::*;
#(
  parameter int unsigned BLK_BITS  = BLK_BITS_DEF,
  parameter int unsigned WORD_W    = WORD_W_DEF,
  parameter int unsigned IDX_W     = IDX_W_DEF,
  localparam int unsigned CNT_W     = $clog2(BLK_BITS),
  localparam int unsigned NUM_WORDS = BLK_BITS / WORD_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                frame_vld_i,
  input logic                sub_b_i,
  input logic                blk_start_i,
  input logic                chan_sel_i,
  input logic [IDX_W-1:0]    word_idx_i,
  input logic [WORD_W-1:0]   word_o,
  input logic                valid_o,
  input logic                commit_i,
  input logic [CNT_W-1:0]    cnt_i,
  input logic [BLK_BITS-1:0] live_i
);
  assert_foreign_ignored_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && (sub_b_i != chan_sel_i) && !blk_start_i) |=> $stable(cnt_i))
    else $error("R1 other-channel subframe moved the bit count");

  assert_start_restarts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && (sub_b_i == chan_sel_i) && blk_start_i) |=> (cnt_i == CNT_W'(1)))
    else $error("R2 start did not restart the count");

  assert_hold_until_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(live_i))
    else $error("R4 readable copy changed without commit");

  assert_cnt_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i < CNT_W'(BLK_BITS))
    else $error("R6 bit count out of range");

  assert_pad_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_idx_i >= IDX_W'(NUM_WORDS)) |-> (word_o == '0))
    else $error("R7 unused index read non-zero");

  assert_valid_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o)
    else $error("R8 valid dropped");

  assert_commit_sets_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> valid_o)
    else $error("R8 commit left valid low");
endmodule

bind cstat_capture cstat_capture_chk #(
  .BLK_BITS(BLK_BITS), .WORD_W(WORD_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_vld_i (frame_vld_i),
  .sub_b_i     (sub_b_i),
  .blk_start_i (blk_start_i),
  .chan_sel_i  (chan_sel_i),
  .word_idx_i  (word_idx_i),
  .word_o      (word_o),
  .valid_o     (valid_o),
  .commit_i    (commit_w),
  .cnt_i       (bit_cnt_w),
  .live_i      (live_w)
);

// File: tb/cstat_capture_bench.sv
module cstat_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_vld = 1'b0;
  logic        cbit = 1'b0;
  logic        sub_b = 1'b0;
  logic        blk_start = 1'b0;
  logic        chan_sel = 1'b0;
  logic [2:0]  word_idx = 3'd0;
  logic [31:0] word;
  logic        valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cstat_capture u_cstat_capture (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .frame_vld_i (frame_vld),
    .cbit_i      (cbit),
    .sub_b_i     (sub_b),
    .blk_start_i (blk_start),
    .chan_sel_i  (chan_sel),
    .word_idx_i  (word_idx),
    .word_o      (word),
    .valid_o     (valid)
  );

  // {chan_sel, seed for channel A, seed for channel B}
  localparam logic [64:0] VECS [4] = '{
    {1'b0, 32'h1234_5678, 32'h9ABC_DEF0},
    {1'b1, 32'h0F0F_3C3C, 32'hA5A5_5A5A},
    {1'b0, 32'hDEAD_BEEF, 32'h0BAD_F00D},
    {1'b1, 32'h7777_1111, 32'h3141_5926}
  };

  function automatic logic pbit(input logic [31:0] seed, input int n);
    logic [31:0] x;
    x = seed ^ (32'(n) * 32'h9E37_79B1);
    x = x ^ (x >> 13);
    return x[5] ^ x[19];
  endfunction

  function automatic logic [191:0] blk_of(input logic [31:0] seed);
    logic [191:0] v;
    for (int n = 0; n < 192; n++) v[n] = pbit(seed, n);
    return v;
  endfunction

  task automatic strobe(input logic b, input logic c, input logic st);
    @(negedge clk);
    frame_vld = 1'b1; sub_b = b; cbit = c; blk_start = st;
  endtask

  task automatic idle();
    @(negedge clk);
    frame_vld = 1'b0; blk_start = 1'b0; cbit = 1'b0;
  endtask

  task automatic send_range(input logic [31:0] sa, input logic [31:0] sb,
                            input int first, input int last, input logic st);
    for (int n = first; n <= last; n++) begin
      strobe(1'b0, pbit(sa, n), st && (n == first));
      strobe(1'b1, pbit(sb, n), 1'b0);
    end
    idle();
  endtask

  task automatic send_onehot(input int pos);
    for (int n = 0; n < 192; n++) begin
      strobe(1'b0, (n == pos), (n == 0));
      strobe(1'b1, 1'b1, 1'b0);
    end
    idle();
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    word_idx = 3'(idx);
    #1;
    v = word;
  endtask

  task automatic chk_block(input string req, input logic [191:0] exp);
    logic [31:0] v;
    for (int i = 0; i < 6; i++) begin
      rd(i, v);
      chk(req, v, exp[i*32 +: 32]);
    end
  endtask

  task automatic chk_valid(input string req, input logic exp);
    #1;
    chk(req, {31'd0, valid}, {31'd0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 / R9: reset state
    chk_valid("R8 reset valid", 1'b0);
    chk_block("R9 reset words", 192'd0);

    // R6: bits before any start are ignored
    chan_sel = 1'b0;
    send_range(32'h5555_0001, 32'h5555_0002, 0, 191, 1'b0);
    chk_valid("R6 no start no valid", 1'b0);
    chk_block("R6 no start words zero", 192'd0);

    // table walk: R1 channel selection, R2 start handling, R3 layout, R7 padding
    for (int k = 0; k < 4; k++) begin
      chan_sel = VECS[k][64];
      send_range(VECS[k][63:32], VECS[k][31:0], 0, 191, 1'b1);
      chk_valid("R8 valid after block", 1'b1);
      chk_block("R1 R2 R3 captured block",
                blk_of(VECS[k][64] ? VECS[k][31:0] : VECS[k][63:32]));
      rd(6, v); chk("R7 index 6 zero", v, 32'd0);
      rd(7, v); chk("R7 index 7 zero", v, 32'd0);
    end

    // R3: bit placement
    chan_sel = 1'b0;
    send_onehot(37);
    rd(1, v); chk("R3 bit 37 -> word1 bit5", v, 32'h0000_0020);
    rd(0, v); chk("R3 word0 clear", v, 32'd0);
    send_onehot(191);
    rd(5, v); chk("R3 bit 191 -> word5 bit31", v, 32'h8000_0000);
    rd(1, v); chk("R3 word1 clear", v, 32'd0);

    // R4: commit happens on bit 191 only
    send_range(32'hC0FF_EE00, 32'h1, 0, 191, 1'b1);
    send_range(32'hBEEF_0042, 32'h2, 0, 190, 1'b1);
    chk_block("R4 old block held before bit 191", blk_of(32'hC0FF_EE00));
    send_range(32'hBEEF_0042, 32'h2, 191, 191, 1'b0);
    chk_block("R4 new block after bit 191", blk_of(32'hBEEF_0042));

    // R5: early restart discards partial block
    send_range(32'h1357_9BDF, 32'h3, 0, 99, 1'b1);
    send_range(32'h2468_ACE0, 32'h4, 0, 91, 1'b1);
    chk_block("R5 no commit 192 bits after first start", blk_of(32'hBEEF_0042));
    send_range(32'h2468_ACE0, 32'h4, 92, 191, 1'b0);
    chk_block("R5 restarted block committed", blk_of(32'h2468_ACE0));

    // R6: bits after a completed block without a new start are ignored
    send_range(32'hFFFF_0000, 32'h5, 0, 191, 1'b0);
    chk_block("R6 trailing bits ignored", blk_of(32'h2468_ACE0));
    chk_valid("R8 valid stays high", 1'b1);

    // R9 / R8: reset during operation
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_valid("R8 valid cleared by reset", 1'b0);
    chk_block("R9 words cleared by reset", 192'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule